// File: doc/BRIEF.md
# Line Validation and Burst Blanking Timer

This block times two per-line strobes for a serial data receiver, from a line sync input and the recovered data clock. The first strobe is a validation window. The framing-code detector downstream uses it to decide when a framing byte may be accepted. The second strobe is a blanking pulse. The front-end slicer uses it as a reset pulse near the colour burst. Every output is synchronous to the data clock. The sync input passes through a two-flop synchroniser and then an edge detector. The edge detector fires on either the rising or the falling edge, chosen by a configuration bit.

In timed mode, a detected line edge loads a programmable delay of 0 to 127 clocks. When the delay expires, a window of exactly 13 clocks opens. The same edge also starts the blanking pulse, which lasts 0 to 63 clocks. In pass-through mode, the synchronised line input itself is offered to the framing detector as the validation signal. The internally timed window keeps running in both modes and always appears on a separate monitor output, so its placement can be checked on the board.

The block holds two small state machines. The window machine has three states:
- `W_IDLE`: no window pending.
- `W_DELAY`: counting down the delay.
- `W_OPEN`: window high.

Its transitions are:
- go-delay: `W_IDLE`/`W_DELAY`/`W_OPEN` → `W_DELAY` on an edge with a nonzero delay.
- go-open: any state → `W_OPEN` on an edge with zero delay.
- expire: `W_DELAY` → `W_OPEN` when the delay count ends.
- close: `W_OPEN` → `W_IDLE` after 13 clocks.

The blanking machine has two states:
- `B_IDLE`: pulse low.
- `B_ON`: pulse high.

Its transitions are:
- arm: any state → `B_ON` on an edge with a nonzero width.
- squash: any state → `B_IDLE` on an edge with width 0.
- finish: `B_ON` → `B_IDLE` when the width count ends.

Top module: `line_val_timer`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is asserted, `val_out`, `cbb` and `frame_val` are all 0.
- R2: With `cfg_ext` = 1, `frame_val` equals the value `line_in` held two clock edges earlier.
- R3: With `cfg_ext` = 0, `frame_val` equals the internally timed window that is also seen on `val_out`.
- R4: The internal window, seen on `val_out`, stays high for exactly 13 consecutive clocks when no new edge arrives during it.
- R5: If `line_in` changes to its active level just before rising clock edge 1, `val_out` is first high after clock edge `cfg_delay`+3.
- R6: `cfg_pos` = 1 selects the rising edge of `line_in` and `cfg_pos` = 0 selects the falling edge. The opposite edge produces no window and no blanking pulse.
- R7: The same edge drives `cbb` high from after clock edge 3 for exactly `cfg_blank` clocks.
- R8: A `cfg_blank` value of 0 produces no `cbb` pulse.
- R9: A new active edge during a pending delay, an open window or a blanking pulse restarts both timers from that edge. Only one window results.
- R10: A `cfg_delay` value of 0 opens the window on the clock after the edge is detected, which is clock edge 3.
- R11: `val_out` shows the internal window in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous line sync / validation input |
| cfg_ext | input | 1 | 1: pass the line input through as validation; 0: use the timed window |
| cfg_pos | input | 1 | Active sync edge: 1 rising, 0 falling |
| cfg_delay | input | 7 | Window start delay in clocks |
| cfg_blank | input | 6 | Blanking pulse width in clocks |
| frame_val | output | 1 | Validation signal for the framing detector |
| val_out | output | 1 | Monitor copy of the internal window |
| cbb | output | 1 | Burst blanking pulse |

## Verification
The bench measures the exact clock of the window's first high sample and its width at both delay extremes. A counter that is off by one would shift or stretch the window by one clock. It runs a width-0 blanking case, where a design that underflows its count would emit a 64-clock pulse instead of none. It presents the non-selected sync edge, which a design with inverted polarity would take as a line start. It also sends a second edge in the middle of a delay. A design that queued the event instead of restarting would show two windows or a shortened blanking pulse.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
    localparam int DLY_W_D   = 7;
    localparam int BLK_W_D   = 6;
    localparam int WIN_LEN_D = 13;
    localparam int SYNC_N_D  = 2;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_DELAY = 2'd1,
        W_OPEN  = 2'd2
    } win_st_t;

    typedef enum logic {
        B_IDLE = 1'b0,
        B_ON   = 1'b1
    } blk_st_t;
endpackage

// File: rtl/lvt_sync_edge.sv
module lvt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic pos_sel,
    output logic line_sync,
    output logic edge_hit
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= line_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain[STAGES-1];
    end

    assign line_sync = chain[STAGES-1];

    always_comb begin
        if (pos_sel) edge_hit = line_sync & ~prev_q;
        else         edge_hit = ~line_sync & prev_q;
    end
endmodule

// File: rtl/lvt_win_fsm.sv
module lvt_win_fsm
    import lvt_pkg::*;
#(
    parameter int DLY_W   = DLY_W_D,
    parameter int WIN_LEN = WIN_LEN_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] delay,
    output logic             win_open
);
    localparam int WC_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int CW   = (DLY_W > WC_W) ? DLY_W : WC_W;
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_LEN - 1);

    win_st_t         st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // next state and next count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (start) begin
            if (delay == '0) begin
                st_d  = W_OPEN;
                cnt_d = WIN_LAST;
            end else begin
                st_d  = W_DELAY;
                cnt_d = CW'(delay) - CW'(1);
            end
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    st_d  = W_IDLE;
                    cnt_d = '0;
                end
                W_DELAY: begin
                    if (cnt_q == '0) begin
                        st_d  = W_OPEN;
                        cnt_d = WIN_LAST;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
                W_OPEN: begin
                    if (cnt_q == '0) begin
                        st_d  = W_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
                default: begin
                    st_d  = W_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= W_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            W_OPEN:  win_open = 1'b1;
            W_IDLE,
            W_DELAY: win_open = 1'b0;
            default: win_open = 1'b0;
        endcase
    end
endmodule

// File: rtl/lvt_blank_fsm.sv
module lvt_blank_fsm
    import lvt_pkg::*;
#(
    parameter int BLK_W = BLK_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] width,
    output logic             pulse
);
    blk_st_t          st_q, st_d;
    logic [BLK_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (start) begin
            if (width == '0) begin
                st_d  = B_IDLE;
                cnt_d = '0;
            end else begin
                st_d  = B_ON;
                cnt_d = width - BLK_W'(1);
            end
        end else begin
            unique case (st_q)
                B_IDLE: cnt_d = '0;
                B_ON: begin
                    if (cnt_q == '0) st_d = B_IDLE;
                    else             cnt_d = cnt_q - BLK_W'(1);
                end
                default: st_d = B_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= B_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        unique case (st_q)
            B_ON:    pulse = 1'b1;
            B_IDLE:  pulse = 1'b0;
            default: pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/line_val_timer.sv
module line_val_timer
    import lvt_pkg::*;
#(
    parameter int DLY_W   = DLY_W_D,
    parameter int BLK_W   = BLK_W_D,
    parameter int WIN_LEN = WIN_LEN_D,
    parameter int SYNC_N  = SYNC_N_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             cfg_ext,
    input  logic             cfg_pos,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [BLK_W-1:0] cfg_blank,
    output logic             frame_val,
    output logic             val_out,
    output logic             cbb
);
    logic line_sync;
    logic edge_hit;
    logic win_open;

    lvt_sync_edge #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .pos_sel   (cfg_pos),
        .line_sync (line_sync),
        .edge_hit  (edge_hit)
    );

    lvt_win_fsm #(.DLY_W(DLY_W), .WIN_LEN(WIN_LEN)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (edge_hit),
        .delay    (cfg_delay),
        .win_open (win_open)
    );

    lvt_blank_fsm #(.BLK_W(BLK_W)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .start (edge_hit),
        .width (cfg_blank),
        .pulse (cbb)
    );

    assign val_out   = win_open;
    assign frame_val = cfg_ext ? line_sync : win_open;
endmodule

// File: rtl/lvt_checker.sv
module lvt_checker #(
    parameter int DLY_W   = 7,
    parameter int BLK_W   = 6,
    parameter int WIN_LEN = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_in,
    input logic             cfg_ext,
    input logic [DLY_W-1:0] cfg_delay,
    input logic [BLK_W-1:0] cfg_blank,
    input logic             edge_hit,
    input logic             frame_val,
    input logic             val_out,
    input logic             cbb
);
    logic [8:0] since_q;
    logic [1:0] up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            up_q    <= '0;
        end else begin
            if (up_q != 2'd3) up_q <= up_q + 2'd1;
            if (edge_hit)                               since_q <= 9'd1;
            else if (since_q != 9'd0 && since_q != 9'h1FF) since_q <= since_q + 9'd1;
        end
    end

    // R1: outputs quiet in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!val_out && !cbb && !frame_val);
        end
    end

    // R2: pass-through latency of two edges
    a_r2_ext_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ext && up_q >= 2'd2) |-> (frame_val == $past(line_in, 2)));

    // R4, R5, R10: window lies in clocks delay+1 .. delay+WIN_LEN after the edge
    a_r5_window_place: assert property (@(posedge clk) disable iff (!rst_n)
        val_out |-> (since_q >= ({2'b0, cfg_delay} + 9'd1) &&
                     since_q <= ({2'b0, cfg_delay} + 9'(WIN_LEN))));

    // R7, R8: blanking lies in clocks 1 .. width after the edge
    a_r7_blank_span: assert property (@(posedge clk) disable iff (!rst_n)
        cbb |-> (since_q >= 9'd1 && since_q <= {3'b0, cfg_blank}));

    // R10: zero delay opens the window right after the edge
    a_r10_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && cfg_delay == '0) |=> val_out);
endmodule

bind line_val_timer lvt_checker #(.DLY_W(DLY_W), .BLK_W(BLK_W), .WIN_LEN(WIN_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .cfg_ext   (cfg_ext),
    .cfg_delay (cfg_delay),
    .cfg_blank (cfg_blank),
    .edge_hit  (edge_hit),
    .frame_val (frame_val),
    .val_out   (val_out),
    .cbb       (cbb)
);

// File: tb/sim_line_val_timer.sv
`timescale 1ns/1ps
module sim_line_val_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       cfg_ext = 1'b0;
    logic       cfg_pos = 1'b1;
    logic [6:0] cfg_delay = '0;
    logic [5:0] cfg_blank = '0;
    logic       frame_val, val_out, cbb;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_val_timer u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_ext(cfg_ext),
        .cfg_pos(cfg_pos), .cfg_delay(cfg_delay), .cfg_blank(cfg_blank),
        .frame_val(frame_val), .val_out(val_out), .cbb(cbb)
    );

    typedef struct packed {
        logic       ext;
        logic       pos;
        logic [6:0] dly;
        logic [5:0] bw;
        logic [7:0] ws;   // expected first window sample
        logic [6:0] cs;   // expected first blanking sample, 0 = none
        logic [6:0] cc;   // expected blanking length
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 7'd0,   6'd5,  8'd3,   7'd3, 7'd5},
        '{1'b0, 1'b1, 7'd7,   6'd0,  8'd10,  7'd0, 7'd0},
        '{1'b0, 1'b0, 7'd12,  6'd63, 8'd15,  7'd3, 7'd63},
        '{1'b0, 1'b1, 7'd127, 6'd1,  8'd130, 7'd3, 7'd1},
        '{1'b0, 1'b0, 7'd1,   6'd20, 8'd4,   7'd3, 7'd20},
        '{1'b1, 1'b1, 7'd40,  6'd10, 8'd43,  7'd3, 7'd10},
        '{1'b1, 1'b0, 7'd5,   6'd2,  8'd8,   7'd3, 7'd2},
        '{1'b0, 1'b1, 7'd127, 6'd63, 8'd130, 7'd3, 7'd63}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one line: idle, active edge, optional restart at sample rs
    task automatic run_line(input logic ext, input logic pos, input logic [6:0] d,
                            input logic [5:0] w, input int rs,
                            output int fw, output int wc, output int fc,
                            output int cc, output int ff, output int mm);
        @(negedge clk);
        cfg_ext = ext; cfg_pos = pos; cfg_delay = d; cfg_blank = w;
        line_in = ~pos;
        repeat (160) @(negedge clk);
        fw = 0; wc = 0; fc = 0; cc = 0; ff = 0; mm = 0;
        line_in = pos;
        for (int i = 1; i <= 200; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (val_out) begin if (fw == 0) fw = i; wc++; end
            if (cbb)     begin if (fc == 0) fc = i; cc++; end
            if (!ext && frame_val != val_out) mm++;
            if (ext && ff == 0 && frame_val == pos) ff = i;
            if (rs != 0 && i == rs - 6) line_in = ~pos;
            if (rs != 0 && i == rs)     line_in = pos;
        end
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int fw, wc, fc, cc, ff, mm;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 val_out in reset", int'(val_out), 0);
        chk("R1 cbb in reset", int'(cbb), 0);
        chk("R1 frame_val in reset", int'(frame_val), 0);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R5 R7 R8 R10 R11
        for (int v = 0; v < NV; v++) begin
            run_line(VEC[v].ext, VEC[v].pos, VEC[v].dly, VEC[v].bw, 0,
                     fw, wc, fc, cc, ff, mm);
            chk($sformatf("R5 R10 R11 window start vec %0d", v), fw, int'(VEC[v].ws));
            chk($sformatf("R4 window width vec %0d", v), wc, 13);
            chk($sformatf("R7 R8 blank start vec %0d", v), fc, int'(VEC[v].cs));
            chk($sformatf("R7 R8 blank length vec %0d", v), cc, int'(VEC[v].cc));
            if (VEC[v].ext) chk($sformatf("R2 pass-through latency vec %0d", v), ff, 2);
            else            chk($sformatf("R3 frame_val follows window vec %0d", v), mm, 0);
        end

        // R6: the opposite edge is ignored
        @(negedge clk);
        cfg_ext = 1'b0; cfg_pos = 1'b1; cfg_delay = 7'd3; cfg_blank = 6'd9;
        line_in = 1'b1;
        repeat (160) @(negedge clk);
        line_in = 1'b0;
        wc = 0; cc = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (val_out) wc++;
            if (cbb) cc++;
        end
        chk("R6 no window on falling edge when rising selected", wc, 0);
        chk("R6 no blanking on falling edge when rising selected", cc, 0);

        // R9: restart from a second edge during the delay
        run_line(1'b0, 1'b1, 7'd20, 6'd30, 10, fw, wc, fc, cc, ff, mm);
        chk("R9 restarted window start", fw, 33);
        chk("R9 single window width", wc, 13);
        chk("R9 blanking start", fc, 3);
        chk("R9 blanking extended by restart", cc, 40);

        // R1: reset asserted in the middle of a window
        @(negedge clk);
        cfg_pos = 1'b1; cfg_delay = 7'd0; cfg_blank = 6'd63; line_in = 1'b0;
        repeat (160) @(negedge clk);
        line_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 window open before reset", int'(val_out), 1);
        rst_n = 1'b0;
        #1;
        chk("R1 val_out cleared by reset", int'(val_out), 0);
        chk("R1 cbb cleared by reset", int'(cbb), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule